// File: doc/BRIEF.md
# Segmentable Deflection Torus Router Tile

This block is one switching tile of a unidirectional two-dimensional torus in which packets are never buffered. Horizontal traffic arrives from the West and leaves to the East. Vertical traffic arrives from the North and leaves to the South. A local client can inject one packet per cycle. The South output also serves as the client's delivery port. Routing finishes the horizontal leg first. A packet that cannot turn where it wants keeps travelling on its own ring and tries again on its next lap.

Each ring input has a second source, the wrap input. It carries the East output of the last tile in the segment. Two split bits sit in a small configuration register. When a split bit is set, the tile takes that ring's traffic from the wrap input instead of from its upstream neighbour. The ring then breaks into sub-rings that no packet can leave. Software sets the split bits through an address/data/write-enable port, and they normally stay fixed for long program phases.

A packet is a flat vector {y, x, payload}. The payload occupies the low `D_W` bits, x the next `X_W` bits, and y the top `Y_W` bits. A tile owns the coordinates (`MY_X`, `MY_Y`).

Top module: `segtor_router`

## Requirements
- R1: While reset is applied, and once it is released, every output flag (`e_vld_o`, `s_vld_o`, `s_dlv_o`) is low and both split bits are clear.
- R2: A valid packet on the effective North input always leaves on the South port one cycle later and never on the East port. It is flagged as delivered (`s_dlv_o`) when its x and y both equal the tile's coordinates, and as forwarded (`s_vld_o`) otherwise.
- R3: A valid packet on the effective West input whose x differs from `MY_X` appears unchanged on the East output one cycle later.
- R4: A valid West packet whose x equals `MY_X` turns onto the South port one cycle later when no North packet is present. It is delivered if its y also matches and forwarded otherwise.
- R5: When a turning West packet meets a valid North packet, the North packet takes the South port and the West packet is deflected unchanged to the East output.
- R6: The client packet goes East when its x differs from `MY_X` and South otherwise. `inj_rdy_o` is high only when that output is not claimed by an in-flight packet. An accepted packet appears on its output one cycle later.
- R7: A write with `cfg_addr_i` equal to `CFG_ID` loads `cfg_wdata_i` into the split bits (bit 0 = East split, bit 1 = South split). Routing follows the new value from the cycle after the write. Writes to any other address change nothing.
- R8: With the East split set, the West side of the tile reads `ew_vld_i`/`ew_pkt_i` and ignores `w_vld_i`. With the South split set, the North side reads `sw_vld_i`/`sw_pkt_i` and ignores `n_vld_i`.
- R9: Delivered and forwarded are never flagged together on the South port. Every packet accepted in a cycle appears exactly once on the outputs of the next cycle.
- R10: In a six-tile X ring, with the East split set at tiles 0 and 3 and each of those tiles wrapped from tiles 2 and 5, every packet addressed within its own three-tile segment is delivered exactly once at its destination. A packet addressed outside its segment is never delivered. With no split set, packets reach any tile on the full ring, including across the wrap point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| w_vld_i | input | 1 | West link packet valid |
| w_pkt_i | input | PKT_W | West link packet |
| ew_vld_i | input | 1 | East-wrap packet valid (segment turn-back) |
| ew_pkt_i | input | PKT_W | East-wrap packet |
| n_vld_i | input | 1 | North link packet valid |
| n_pkt_i | input | PKT_W | North link packet |
| sw_vld_i | input | 1 | South-wrap packet valid |
| sw_pkt_i | input | PKT_W | South-wrap packet |
| inj_vld_i | input | 1 | Client injection request |
| inj_pkt_i | input | PKT_W | Client packet |
| inj_rdy_o | output | 1 | Client packet accepted this cycle |
| e_vld_o | output | 1 | East link packet valid |
| e_pkt_o | output | PKT_W | East link packet |
| s_vld_o | output | 1 | South link packet valid (forwarded) |
| s_dlv_o | output | 1 | South port packet is delivered to the client |
| s_pkt_o | output | PKT_W | South / delivery packet |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_addr_i | input | CFG_AW | Configuration write address |
| cfg_wdata_i | input | 2 | Split bits to write (bit 0 East, bit 1 South) |

## Verification
The assertions check four things on every cycle:
- the South port is never both delivered and forwarded;
- the number of packets in equals the number out one cycle later;
- vertical traffic never leaves East, and always gets the South port;
- non-turning and deflected West packets pass East unchanged; configuration writes load or hold the split bits as addressed.

Only the bench's scenarios can show the rest:
- which output a packet lands on, and whether it is delivered or forwarded, for a given header;
- that the client is refused when its output is taken;
- that a split takes effect exactly one cycle after the write, and that the ignored input really has no effect;
- that in a fractured ring every packet is delivered exactly once inside its own segment and never beyond it.

// File: rtl/segtor_pkg.sv
package segtor_pkg;

  // Split register layout: one bit per ring dimension.
  localparam int SPLIT_W     = 2;
  localparam int SPLIT_EAST  = 0;
  localparam int SPLIT_SOUTH = 1;

  // Source feeding an output register in a given cycle.
  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_NORTH  = 2'd1,
    SRC_WEST   = 2'd2,
    SRC_CLIENT = 2'd3
  } src_e;

endpackage

// File: rtl/segtor_rst_sync.sv
module segtor_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/segtor_cfg.sv
module segtor_cfg #(
  parameter int AW = 4,
  parameter int ID = 0,
  parameter int SW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [SW-1:0] wdata,
  output logic [SW-1:0] split_q
);

  localparam logic [AW-1:0] MY_ADDR = AW'(ID);

  logic          hit;
  logic [SW-1:0] split_d;

  always_comb begin
    hit     = we && (addr == MY_ADDR);
    split_d = hit ? wdata : split_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      split_q <= '0;
    end else begin
      split_q <= split_d;
    end
  end

  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == MY_ADDR) |=> (split_q == $past(wdata))); // R7
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && addr == MY_ADDR) |=> $stable(split_q)); // R7

endmodule

// File: rtl/segtor_route.sv
module segtor_route
  import segtor_pkg::*;
#(
  parameter int X_W   = 3,
  parameter int Y_W   = 3,
  parameter int D_W   = 10,
  parameter int MY_X  = 0,
  parameter int MY_Y  = 0,
  parameter int PKT_W = X_W + Y_W + D_W
) (
  input  logic             w_vld,
  input  logic [PKT_W-1:0] w_pkt,
  input  logic             n_vld,
  input  logic [PKT_W-1:0] n_pkt,
  input  logic             inj_vld,
  input  logic [PKT_W-1:0] inj_pkt,
  output logic             inj_rdy,
  output logic             e_vld_d,
  output logic [PKT_W-1:0] e_pkt_d,
  output logic             s_fwd_d,
  output logic             s_dlv_d,
  output logic [PKT_W-1:0] s_pkt_d
);

  localparam int XL = D_W;
  localparam int YL = D_W + X_W;
  localparam logic [X_W-1:0] MX = X_W'(MY_X);
  localparam logic [Y_W-1:0] MYY = Y_W'(MY_Y);

  function automatic logic col_hit(input logic [PKT_W-1:0] p);
    return p[XL +: X_W] == MX;
  endfunction

  function automatic logic tile_hit(input logic [PKT_W-1:0] p);
    return (p[XL +: X_W] == MX) && (p[YL +: Y_W] == MYY);
  endfunction

  src_e s_src;
  src_e e_src;
  logic w_turn;
  logic inj_south;
  logic s_any;

  // Dimension-ordered arbitration: vertical traffic owns South,
  // a turning West packet takes South only when it is free, and
  // the client fills whatever its target output leaves unclaimed.
  always_comb begin
    w_turn    = w_vld && col_hit(w_pkt);
    inj_south = col_hit(inj_pkt);
    s_src     = SRC_NONE;
    e_src     = SRC_NONE;
    if (n_vld) begin
      s_src = SRC_NORTH;
    end else if (w_turn) begin
      s_src = SRC_WEST;
    end
    if (w_vld && (s_src != SRC_WEST)) begin
      e_src = SRC_WEST;
    end
    inj_rdy = inj_south ? (s_src == SRC_NONE) : (e_src == SRC_NONE);
    if (inj_vld && inj_rdy) begin
      if (inj_south) begin
        s_src = SRC_CLIENT;
      end else begin
        e_src = SRC_CLIENT;
      end
    end
  end

  always_comb begin
    case (e_src)
      SRC_WEST:   e_pkt_d = w_pkt;
      SRC_CLIENT: e_pkt_d = inj_pkt;
      default:    e_pkt_d = '0;
    endcase
    e_vld_d = (e_src != SRC_NONE);
  end

  always_comb begin
    case (s_src)
      SRC_NORTH:  s_pkt_d = n_pkt;
      SRC_WEST:   s_pkt_d = w_pkt;
      SRC_CLIENT: s_pkt_d = inj_pkt;
      default:    s_pkt_d = '0;
    endcase
    s_any   = (s_src != SRC_NONE);
    s_dlv_d = s_any && tile_hit(s_pkt_d);
    s_fwd_d = s_any && !tile_hit(s_pkt_d);
  end

endmodule

// File: rtl/segtor_link_reg.sv
module segtor_link_reg #(
  parameter int FLAG_W = 1,
  parameter int PKT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_W-1:0] flag_d,
  input  logic [PKT_W-1:0]  pkt_d,
  output logic [FLAG_W-1:0] flag_q,
  output logic [PKT_W-1:0]  pkt_q
);

  logic             load_en;
  logic [PKT_W-1:0] pkt_nxt;

  always_comb begin
    load_en = |flag_d;
    pkt_nxt = load_en ? pkt_d : pkt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      pkt_q  <= '0;
    end else begin
      flag_q <= flag_d;
      pkt_q  <= pkt_nxt;
    end
  end

endmodule

// File: rtl/segtor_router.sv
module segtor_router
  import segtor_pkg::*;
#(
  parameter int X_W    = 3,
  parameter int Y_W    = 3,
  parameter int D_W    = 10,
  parameter int MY_X   = 0,
  parameter int MY_Y   = 0,
  parameter int CFG_AW = 4,
  parameter int CFG_ID = 0,
  parameter int PKT_W  = X_W + Y_W + D_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              w_vld_i,
  input  logic [PKT_W-1:0]  w_pkt_i,
  input  logic              ew_vld_i,
  input  logic [PKT_W-1:0]  ew_pkt_i,
  input  logic              n_vld_i,
  input  logic [PKT_W-1:0]  n_pkt_i,
  input  logic              sw_vld_i,
  input  logic [PKT_W-1:0]  sw_pkt_i,
  input  logic              inj_vld_i,
  input  logic [PKT_W-1:0]  inj_pkt_i,
  output logic              inj_rdy_o,
  output logic              e_vld_o,
  output logic [PKT_W-1:0]  e_pkt_o,
  output logic              s_vld_o,
  output logic              s_dlv_o,
  output logic [PKT_W-1:0]  s_pkt_o,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [1:0]        cfg_wdata_i
);

  localparam int XL = D_W;
  localparam logic [X_W-1:0] MX = X_W'(MY_X);

  logic               rst_n_s;
  logic [SPLIT_W-1:0] split_q;

  // Per-dimension isolation mux inputs: index 0 = X ring, 1 = Y ring.
  logic [SPLIT_W-1:0] link_vld;
  logic [SPLIT_W-1:0] wrap_vld;
  logic [SPLIT_W-1:0] eff_vld;
  logic [PKT_W-1:0]   link_pkt [SPLIT_W];
  logic [PKT_W-1:0]   wrap_pkt [SPLIT_W];
  logic [PKT_W-1:0]   eff_pkt  [SPLIT_W];

  logic             e_vld_d;
  logic [PKT_W-1:0] e_pkt_d;
  logic             s_fwd_d;
  logic             s_dlv_d;
  logic [PKT_W-1:0] s_pkt_d;
  logic [1:0]       s_flags_q;
  logic [1:0]       in_cnt;

  segtor_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  segtor_cfg #(.AW(CFG_AW), .ID(CFG_ID), .SW(SPLIT_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .we      (cfg_we_i),
    .addr    (cfg_addr_i),
    .wdata   (cfg_wdata_i),
    .split_q (split_q)
  );

  always_comb begin
    link_vld[SPLIT_EAST]  = w_vld_i;
    link_pkt[SPLIT_EAST]  = w_pkt_i;
    wrap_vld[SPLIT_EAST]  = ew_vld_i;
    wrap_pkt[SPLIT_EAST]  = ew_pkt_i;
    link_vld[SPLIT_SOUTH] = n_vld_i;
    link_pkt[SPLIT_SOUTH] = n_pkt_i;
    wrap_vld[SPLIT_SOUTH] = sw_vld_i;
    wrap_pkt[SPLIT_SOUTH] = sw_pkt_i;
  end

  for (genvar g = 0; g < SPLIT_W; g++) begin : g_iso
    assign eff_vld[g] = split_q[g] ? wrap_vld[g] : link_vld[g];
    assign eff_pkt[g] = split_q[g] ? wrap_pkt[g] : link_pkt[g];
  end

  segtor_route #(
    .X_W(X_W), .Y_W(Y_W), .D_W(D_W), .MY_X(MY_X), .MY_Y(MY_Y), .PKT_W(PKT_W)
  ) u_route (
    .w_vld   (eff_vld[SPLIT_EAST]),
    .w_pkt   (eff_pkt[SPLIT_EAST]),
    .n_vld   (eff_vld[SPLIT_SOUTH]),
    .n_pkt   (eff_pkt[SPLIT_SOUTH]),
    .inj_vld (inj_vld_i),
    .inj_pkt (inj_pkt_i),
    .inj_rdy (inj_rdy_o),
    .e_vld_d (e_vld_d),
    .e_pkt_d (e_pkt_d),
    .s_fwd_d (s_fwd_d),
    .s_dlv_d (s_dlv_d),
    .s_pkt_d (s_pkt_d)
  );

  segtor_link_reg #(.FLAG_W(1), .PKT_W(PKT_W)) u_east_reg (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .flag_d (e_vld_d),
    .pkt_d  (e_pkt_d),
    .flag_q (e_vld_o),
    .pkt_q  (e_pkt_o)
  );

  segtor_link_reg #(.FLAG_W(2), .PKT_W(PKT_W)) u_south_reg (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .flag_d ({s_dlv_d, s_fwd_d}),
    .pkt_d  (s_pkt_d),
    .flag_q (s_flags_q),
    .pkt_q  (s_pkt_o)
  );

  assign s_vld_o = s_flags_q[0];
  assign s_dlv_o = s_flags_q[1];

  always_comb begin
    in_cnt = 2'(eff_vld[SPLIT_EAST]) + 2'(eff_vld[SPLIT_SOUTH])
           + 2'(inj_vld_i && inj_rdy_o);
  end

  AST_SOUTH_EXCL: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(s_vld_o && s_dlv_o)); // R9
  AST_CONSERVE: assert property (@(posedge clk) disable iff (!rst_n_s)
    $past(rst_n_s) |-> ($countones({e_vld_o, s_vld_o, s_dlv_o}) == int'($past(in_cnt)))); // R9
  AST_VERT_OWNS_SOUTH: assert property (@(posedge clk) disable iff (!rst_n_s)
    eff_vld[SPLIT_SOUTH] |=> ((s_vld_o || s_dlv_o) && s_pkt_o == $past(eff_pkt[SPLIT_SOUTH]))); // R2
  AST_VERT_NO_EAST: assert property (@(posedge clk) disable iff (!rst_n_s)
    (eff_vld[SPLIT_SOUTH] && !eff_vld[SPLIT_EAST] && !(inj_vld_i && inj_rdy_o)) |=> !e_vld_o); // R2
  AST_EAST_PASS: assert property (@(posedge clk) disable iff (!rst_n_s)
    (eff_vld[SPLIT_EAST] && eff_pkt[SPLIT_EAST][XL +: X_W] != MX)
      |=> (e_vld_o && e_pkt_o == $past(eff_pkt[SPLIT_EAST]))); // R3
  AST_DEFLECT: assert property (@(posedge clk) disable iff (!rst_n_s)
    (eff_vld[SPLIT_EAST] && eff_vld[SPLIT_SOUTH])
      |=> (e_vld_o && e_pkt_o == $past(eff_pkt[SPLIT_EAST]))); // R5

endmodule

// File: tb/segtor_router_tb.sv
module segtor_router_tb;

  localparam int CLK_PERIOD = 10;
  localparam int PW = 16;
  localparam int NT = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  // ---------------- single tile at (2,1), config address 5 ----------------
  logic          w_vld, ew_vld, n_vld, sw_vld, inj_vld, inj_rdy;
  logic [PW-1:0] w_pkt, ew_pkt, n_pkt, sw_pkt, inj_pkt;
  logic          e_vld, s_vld, s_dlv;
  logic [PW-1:0] e_pkt, s_pkt;
  logic          cfg_we;
  logic [3:0]    cfg_addr;
  logic [1:0]    cfg_wd;

  segtor_router #(.X_W(3), .Y_W(3), .D_W(10), .MY_X(2), .MY_Y(1),
                  .CFG_AW(4), .CFG_ID(5)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .w_vld_i(w_vld), .w_pkt_i(w_pkt), .ew_vld_i(ew_vld), .ew_pkt_i(ew_pkt),
    .n_vld_i(n_vld), .n_pkt_i(n_pkt), .sw_vld_i(sw_vld), .sw_pkt_i(sw_pkt),
    .inj_vld_i(inj_vld), .inj_pkt_i(inj_pkt), .inj_rdy_o(inj_rdy),
    .e_vld_o(e_vld), .e_pkt_o(e_pkt), .s_vld_o(s_vld), .s_dlv_o(s_dlv),
    .s_pkt_o(s_pkt), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wd)
  );

  // ---------------- six-tile X ring, Y ring of one ----------------
  logic          r_e_vld [NT];
  logic [PW-1:0] r_e_pkt [NT];
  logic          r_s_vld [NT];
  logic          r_s_dlv [NT];
  logic [PW-1:0] r_s_pkt [NT];
  logic          r_inj_rdy [NT];
  logic          r_inj_vld [NT];
  logic [PW-1:0] r_inj_pkt [NT];
  logic          r_we;
  logic [3:0]    r_addr;
  logic [1:0]    r_wd;

  for (genvar g = 0; g < NT; g++) begin : g_ring
    localparam int PREV = (g + NT - 1) % NT;
    localparam int WRAP = (g % 3 == 0) ? g + 2 : PREV;
    segtor_router #(.X_W(3), .Y_W(3), .D_W(10), .MY_X(g), .MY_Y(0),
                    .CFG_AW(4), .CFG_ID(g)) u_tile (
      .clk(clk), .rst_n(rst_n),
      .w_vld_i(r_e_vld[PREV]), .w_pkt_i(r_e_pkt[PREV]),
      .ew_vld_i(r_e_vld[WRAP]), .ew_pkt_i(r_e_pkt[WRAP]),
      .n_vld_i(r_s_vld[g]), .n_pkt_i(r_s_pkt[g]),
      .sw_vld_i(r_s_vld[g]), .sw_pkt_i(r_s_pkt[g]),
      .inj_vld_i(r_inj_vld[g]), .inj_pkt_i(r_inj_pkt[g]), .inj_rdy_o(r_inj_rdy[g]),
      .e_vld_o(r_e_vld[g]), .e_pkt_o(r_e_pkt[g]), .s_vld_o(r_s_vld[g]),
      .s_dlv_o(r_s_dlv[g]), .s_pkt_o(r_s_pkt[g]),
      .cfg_we_i(r_we), .cfg_addr_i(r_addr), .cfg_wdata_i(r_wd)
    );
  end

  int dcnt  [64] = '{default: 0};
  int dtile [64] = '{default: -1};

  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < NT; i++) begin
        if (r_s_dlv[i]) begin
          dcnt[r_s_pkt[i][5:0]]  = dcnt[r_s_pkt[i][5:0]] + 1;
          dtile[r_s_pkt[i][5:0]] = i;
        end
      end
    end
  end

  function automatic logic [PW-1:0] mk(input int x, input int y, input int d);
    return {3'(y), 3'(x), 10'(d)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    w_vld = 0; ew_vld = 0; n_vld = 0; sw_vld = 0; inj_vld = 0;
    w_pkt = '0; ew_pkt = '0; n_pkt = '0; sw_pkt = '0; inj_pkt = '0;
    cfg_we = 0; cfg_addr = '0; cfg_wd = '0;
  endtask

  task automatic t_reset();
    chk("R1 e_vld", 32'(e_vld), 0);
    chk("R1 s_vld", 32'(s_vld), 0);
    chk("R1 s_dlv", 32'(s_dlv), 0);
    for (int i = 0; i < NT; i++) chk("R1 ring e_vld", 32'(r_e_vld[i]), 0);
  endtask

  task automatic t_north();
    @(negedge clk); idle(); n_vld = 1; n_pkt = mk(2, 3, 10'h055);
    @(negedge clk);
    chk("R2 fwd", 32'(s_vld), 1); chk("R2 not dlv", 32'(s_dlv), 0);
    chk("R2 pkt", 32'(s_pkt), 32'(mk(2, 3, 10'h055))); chk("R2 no east", 32'(e_vld), 0);
    n_pkt = mk(2, 1, 10'h0AA);
    @(negedge clk);
    chk("R2 dlv", 32'(s_dlv), 1); chk("R2 dlv not fwd", 32'(s_vld), 0);
    chk("R2 dlv pkt", 32'(s_pkt), 32'(mk(2, 1, 10'h0AA)));
    n_pkt = mk(6, 3, 10'h0B1);
    @(negedge clk);
    chk("R2 odd x stays south", 32'(s_vld), 1); chk("R2 odd x no east", 32'(e_vld), 0);
    idle();
  endtask

  task automatic t_west();
    @(negedge clk); idle(); w_vld = 1; w_pkt = mk(5, 0, 10'h123);
    @(negedge clk);
    chk("R3 east", 32'(e_vld), 1); chk("R3 pkt", 32'(e_pkt), 32'(mk(5, 0, 10'h123)));
    chk("R3 south idle", 32'(s_vld | s_dlv), 0);
    w_pkt = mk(2, 6, 10'h124);
    @(negedge clk);
    chk("R4 turn fwd", 32'(s_vld), 1); chk("R4 turn no east", 32'(e_vld), 0);
    chk("R4 turn pkt", 32'(s_pkt), 32'(mk(2, 6, 10'h124)));
    w_pkt = mk(2, 1, 10'h125);
    @(negedge clk);
    chk("R4 turn dlv", 32'(s_dlv), 1); chk("R4 turn dlv pkt", 32'(s_pkt), 32'(mk(2, 1, 10'h125)));
    idle();
  endtask

  task automatic t_deflect();
    @(negedge clk); idle();
    w_vld = 1; w_pkt = mk(2, 1, 10'h111); n_vld = 1; n_pkt = mk(2, 4, 10'h222);
    @(negedge clk);
    chk("R5 north wins", 32'(s_pkt), 32'(mk(2, 4, 10'h222)));
    chk("R5 south fwd", 32'(s_vld), 1); chk("R5 no dlv", 32'(s_dlv), 0);
    chk("R5 deflected east", 32'(e_vld), 1);
    chk("R5 deflect pkt", 32'(e_pkt), 32'(mk(2, 1, 10'h111)));
    idle();
  endtask

  task automatic t_inject();
    @(negedge clk); idle();
    w_vld = 1; w_pkt = mk(3, 0, 10'h301); inj_vld = 1; inj_pkt = mk(4, 0, 10'h302);
    #1 chk("R6 east busy refuses", 32'(inj_rdy), 0);
    @(negedge clk);
    chk("R6 in-flight keeps east", 32'(e_pkt), 32'(mk(3, 0, 10'h301)));
    w_vld = 0;
    #1 chk("R6 east free accepts", 32'(inj_rdy), 1);
    @(negedge clk);
    chk("R6 injected east", 32'(e_vld), 1); chk("R6 inj pkt", 32'(e_pkt), 32'(mk(4, 0, 10'h302)));
    n_vld = 1; n_pkt = mk(2, 5, 10'h303); inj_pkt = mk(2, 1, 10'h304);
    #1 chk("R6 south busy refuses", 32'(inj_rdy), 0);
    @(negedge clk);
    n_vld = 0; w_vld = 1; w_pkt = mk(2, 6, 10'h305);
    #1 chk("R6 turning west blocks", 32'(inj_rdy), 0);
    @(negedge clk);
    w_pkt = mk(5, 0, 10'h306);
    #1 chk("R6 south free accepts", 32'(inj_rdy), 1);
    @(negedge clk);
    chk("R6 self delivery", 32'(s_dlv), 1); chk("R6 self pkt", 32'(s_pkt), 32'(mk(2, 1, 10'h304)));
    chk("R9 both outputs", 32'(e_pkt), 32'(mk(5, 0, 10'h306)));
    idle();
  endtask

  task automatic t_cfg();
    @(negedge clk); idle();
    cfg_we = 1; cfg_addr = 4'd3; cfg_wd = 2'b11;
    w_vld = 1; w_pkt = mk(4, 0, 10'h0C1); ew_vld = 1; ew_pkt = mk(5, 0, 10'h0C2);
    @(negedge clk);
    chk("R1 split clear after reset", 32'(e_pkt), 32'(mk(4, 0, 10'h0C1)));
    cfg_we = 0; w_pkt = mk(4, 0, 10'h0C3); ew_pkt = mk(5, 0, 10'h0C4);
    @(negedge clk);
    chk("R7 other address ignored", 32'(e_pkt), 32'(mk(4, 0, 10'h0C3)));
    cfg_we = 1; cfg_addr = 4'd5; cfg_wd = 2'b01;
    w_pkt = mk(4, 0, 10'h0C5); ew_pkt = mk(5, 0, 10'h0C6);
    @(negedge clk);
    chk("R7 old split in write cycle", 32'(e_pkt), 32'(mk(4, 0, 10'h0C5)));
    cfg_we = 0; w_pkt = mk(4, 0, 10'h0C7); ew_pkt = mk(5, 0, 10'h0C8);
    @(negedge clk);
    chk("R8 east wrap used", 32'(e_pkt), 32'(mk(5, 0, 10'h0C8)));
    ew_vld = 0;
    @(negedge clk);
    chk("R8 west ignored", 32'(e_vld), 0);
    w_vld = 0; cfg_we = 1; cfg_wd = 2'b10;
    @(negedge clk);
    cfg_we = 0; n_vld = 1; n_pkt = mk(2, 3, 10'h0D1); sw_vld = 1; sw_pkt = mk(2, 3, 10'h0D2);
    w_vld = 1; w_pkt = mk(4, 0, 10'h0D3); ew_vld = 1; ew_pkt = mk(5, 0, 10'h0D4);
    @(negedge clk);
    chk("R8 south wrap used", 32'(s_pkt), 32'(mk(2, 3, 10'h0D2)));
    chk("R7 east split cleared", 32'(e_pkt), 32'(mk(4, 0, 10'h0D3)));
    sw_vld = 0;
    @(negedge clk);
    chk("R8 north ignored", 32'(s_vld | s_dlv), 0);
    idle(); cfg_we = 1; cfg_addr = 4'd5; cfg_wd = 2'b00;
    @(negedge clk); idle();
  endtask

  task automatic ring_inj(input int src, input int dst, input int tag);
    @(negedge clk);
    r_inj_vld[src] = 1; r_inj_pkt[src] = mk(dst, 0, tag);
    #1;
    while (!r_inj_rdy[src]) begin
      @(negedge clk); #1;
    end
    @(negedge clk);
    r_inj_vld[src] = 0;
  endtask

  task automatic ring_cfg(input int tile, input logic [1:0] val);
    @(negedge clk); r_we = 1; r_addr = 4'(tile); r_wd = val;
    @(negedge clk); r_we = 0;
  endtask

  task automatic t_ring_full();
    ring_inj(0, 4, 40);
    ring_inj(4, 1, 41);
    repeat (20) @(negedge clk);
    chk("R10 full ring count 40", 32'(dcnt[40]), 1); chk("R10 full ring tile 40", 32'(dtile[40]), 4);
    chk("R10 wrap count 41", 32'(dcnt[41]), 1); chk("R10 wrap tile 41", 32'(dtile[41]), 1);
  endtask

  task automatic t_ring_split();
    int exp_dst [24];
    ring_cfg(0, 2'b01);
    ring_cfg(3, 2'b01);
    for (int k = 0; k < 24; k++) begin
      int src = int'($urandom % 6);
      exp_dst[k] = (src / 3) * 3 + int'($urandom % 3);
      ring_inj(src, exp_dst[k], k);
    end
    repeat (40) @(negedge clk);
    for (int k = 0; k < 24; k++) begin
      chk("R10 delivered once", 32'(dcnt[k]), 1);
      chk("R10 inside segment", 32'(dtile[k]), 32'(exp_dst[k]));
    end
    ring_inj(1, 4, 50);
    repeat (40) @(negedge clk);
    chk("R10 no crossing", 32'(dcnt[50]), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle();
    r_we = 0; r_addr = '0; r_wd = '0;
    for (int i = 0; i < NT; i++) begin
      r_inj_vld[i] = 0; r_inj_pkt[i] = '0;
    end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_north();
    t_west();
    t_deflect();
    t_inject();
    t_cfg();
    t_ring_full();
    t_ring_split();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule